// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two 80-bit extended-precision operands, the stack-top value and a selected stack entry, and encodes the result as three condition flags (zero, parity and carry). It also clears an overflow flag, raises an invalid-operand indication and issues a stack-pop request. Each operand is classified as zero, normal, denormal, infinity, quiet NaN, signaling NaN, unsupported encoding or empty. The classes decide whether the operands are ordered and whether an invalid operation is reported.

A compare request is presented on `op_valid`. `op_ready` is tied high, so a request is accepted on every clock edge where `op_valid` is high, and the block never applies back-pressure. Each accepted request is complete one cycle later. The flag, overflow and top-pointer registers then hold their new values. The single-cycle pulses `inv_exc`, `stk_uflow` and `pop_valid` are high for exactly that one cycle. The variant input `op_signaling` selects the signaling compare (1) or the quiet compare (0). `mask_invalid` is the invalid-operation mask bit, and `pop_en` requests a pop after the compare.

Operand format: bit 79 is the sign, bits 78:64 are the biased exponent and bits 63:0 are the significand. Bit 63 is the explicit integer bit.

Top module: `fcmp_flag_unit`

## Requirements
- R1: For ordered operands the flags {zf,pf,cf} become 000 when st0 > sti, 001 when st0 < sti and 100 when they are equal.
- R2: When either operand is a NaN, the flags {zf,pf,cf} become 111 (unordered), provided no unmasked invalid exception occurs.
- R3: Positive and negative zero compare equal in either order and give flags 100.
- R4: In the quiet variant (`op_signaling`=0), a quiet NaN (exponent all ones, bit 63 set, bit 62 set) does not raise `inv_exc`. A signaling NaN (exponent all ones, bit 63 set, bit 62 clear, bits 61:0 nonzero) does raise it.
- R5: In the signaling variant (`op_signaling`=1), any NaN operand raises `inv_exc`.
- R6: When `inv_exc` is raised and `mask_invalid` was 0, zf, pf and cf keep their previous values. When `mask_invalid` was 1, they are written with 111.
- R7: Reset sets zf, pf, cf and of to 1, sets top_ptr to 0 and clears all pulses. Every accepted compare clears `of`, including one that raises an exception.
- R8: An accepted compare with `pop_en`=1 pulses `pop_valid` with `pop_idx` equal to the old top_ptr, and increments the 3-bit top_ptr modulo 8. With `pop_en`=0 the top_ptr is unchanged.
- R9: If `st0_empty` or `sti_empty` is set, the compare pulses both `stk_uflow` and `inv_exc`, and the flags are gated by `mask_invalid` as in R6.
- R10: An operand with a nonzero exponent and bit 63 clear is an unsupported encoding. It is unordered and raises `inv_exc` in both variants.
- R11: Two negative values order by inverted magnitude. Infinities order beyond every finite value, and denormals (exponent zero) order by raw significand.
- R12: Results appear in the cycle after `op_valid` is sampled high. `op_ready` is always 1. A cycle without `op_valid` leaves the flags and top_ptr unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Compare request |
| op_ready | output | 1 | Always 1; the block accepts every request |
| op_signaling | input | 1 | 1 = signaling compare, 0 = quiet compare |
| mask_invalid | input | 1 | Invalid-operation mask bit |
| pop_en | input | 1 | Pop the stack after the compare |
| st0_val | input | 80 | Stack-top operand |
| sti_val | input | 80 | Selected stack-entry operand |
| st0_empty | input | 1 | Stack-top register is tagged empty |
| sti_empty | input | 1 | Selected register is tagged empty |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| inv_exc | output | 1 | Invalid-operand pulse |
| stk_uflow | output | 1 | Stack-underflow pulse |
| pop_valid | output | 1 | Pop request pulse (mark pop_idx empty) |
| pop_idx | output | 3 | Register index to mark empty |
| top_ptr | output | 3 | Top-of-stack pointer |

## Verification
The bench compares positive zero against negative zero in both orders. A design that compares sign bits before checking for zero would report less-than or greater-than here. It compares two negative numbers, an infinity and two denormals, which catch an uninverted magnitude compare and a design that normalizes denormals wrongly. It runs quiet and signaling NaNs, an unnormal and empty tags through both variants with the mask set and clear. A wrong variant decode shows up as a missing or spurious `inv_exc`, and a broken mask gate overwrites flags that should be held. Nine successive pops check that top_ptr wraps from 7 back to 0, and the first exception after reset checks that `of` is still cleared.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int VAL_W = EXP_W + MAN_W + 1;
  localparam int PTR_W = 3;

  typedef enum logic [2:0] {
    CL_ZERO, CL_NORM, CL_DENORM, CL_INF,
    CL_QNAN, CL_SNAN, CL_UNSUP, CL_EMPTY
  } opclass_t;

  typedef enum logic [1:0] {REL_GT, REL_LT, REL_EQ, REL_UN} rel_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] val,
  input  logic           empty,
  output opclass_t       cls
);
  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic          int_bit;
  logic          quiet_bit;
  logic          frac_zero;

  assign exp_f     = val[EW+MW-1:MW];
  assign man_f     = val[MW-1:0];
  assign int_bit   = man_f[MW-1];
  assign quiet_bit = man_f[MW-2];
  assign frac_zero = (man_f[MW-2:0] == '0);

  always_comb begin
    if (empty)                         cls = CL_EMPTY;
    else if (exp_f == '0)              cls = (man_f == '0) ? CL_ZERO : CL_DENORM;
    else if (!int_bit)                 cls = CL_UNSUP;
    else if (exp_f == {EW{1'b1}}) begin
      if (frac_zero)                   cls = CL_INF;
      else if (quiet_bit)              cls = CL_QNAN;
      else                             cls = CL_SNAN;
    end
    else                               cls = CL_NORM;
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] a_val,
  input  logic [EW+MW:0] b_val,
  input  opclass_t       a_cls,
  input  opclass_t       b_cls,
  output rel_t           rel
);
  localparam int MAG_W = EW + MW;

  logic             a_zero, b_zero, a_sgn, b_sgn, unord;
  logic [MAG_W-1:0] a_mag, b_mag;

  function automatic logic is_unord(opclass_t c);
    return (c == CL_QNAN) || (c == CL_SNAN) || (c == CL_UNSUP) || (c == CL_EMPTY);
  endfunction

  assign a_zero = (a_cls == CL_ZERO);
  assign b_zero = (b_cls == CL_ZERO);
  // zeros lose their sign and magnitude so +0 and -0 meet as equals
  assign a_sgn  = a_val[MAG_W] & ~a_zero;
  assign b_sgn  = b_val[MAG_W] & ~b_zero;
  assign a_mag  = a_zero ? '0 : a_val[MAG_W-1:0];
  assign b_mag  = b_zero ? '0 : b_val[MAG_W-1:0];
  assign unord  = is_unord(a_cls) || is_unord(b_cls);

  always_comb begin
    if (unord)               rel = REL_UN;
    else if (a_sgn != b_sgn) rel = a_sgn ? REL_LT : REL_GT;
    else if (a_mag == b_mag) rel = REL_EQ;
    else if ((a_mag > b_mag) ^ a_sgn) rel = REL_GT;
    else                     rel = REL_LT;
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_signaling,
  input  logic             mask_invalid,
  input  logic             pop_en,
  input  logic [VAL_W-1:0] st0_val,
  input  logic [VAL_W-1:0] sti_val,
  input  logic             st0_empty,
  input  logic             sti_empty,
  output logic             zf,
  output logic             pf,
  output logic             cf,
  output logic             of,
  output logic             inv_exc,
  output logic             stk_uflow,
  output logic             pop_valid,
  output logic [PTR_W-1:0] pop_idx,
  output logic [PTR_W-1:0] top_ptr
);
  localparam int NOPS = 2;

  logic [VAL_W-1:0] opv [NOPS];
  logic             ope [NOPS];
  opclass_t         cls [NOPS];
  rel_t             rel;
  logic             any_q, any_s, any_u, any_e, inv_c, wr_flags;
  logic [2:0]       nflags;

  assign opv[0] = st0_val;
  assign opv[1] = sti_val;
  assign ope[0] = st0_empty;
  assign ope[1] = sti_empty;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fcmp_classify #(.EW(EXP_W), .MW(MAN_W)) cls_i (
      .val(opv[g]), .empty(ope[g]), .cls(cls[g])
    );
  end

  fcmp_order #(.EW(EXP_W), .MW(MAN_W)) ord_i (
    .a_val(st0_val), .b_val(sti_val),
    .a_cls(cls[0]), .b_cls(cls[1]), .rel(rel)
  );

  assign any_q = (cls[0] == CL_QNAN)  || (cls[1] == CL_QNAN);
  assign any_s = (cls[0] == CL_SNAN)  || (cls[1] == CL_SNAN);
  assign any_u = (cls[0] == CL_UNSUP) || (cls[1] == CL_UNSUP);
  assign any_e = (cls[0] == CL_EMPTY) || (cls[1] == CL_EMPTY);
  assign inv_c = any_e || any_u || any_s || (op_signaling && any_q);
  assign wr_flags = !inv_c || mask_invalid;

  always_comb begin
    unique case (rel)
      REL_GT:  nflags = 3'b000;
      REL_LT:  nflags = 3'b001;
      REL_EQ:  nflags = 3'b100;
      default: nflags = 3'b111;
    endcase
  end

  assign op_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {zf, pf, cf, of} <= 4'b1111;
      inv_exc   <= 1'b0;
      stk_uflow <= 1'b0;
      pop_valid <= 1'b0;
      pop_idx   <= '0;
      top_ptr   <= '0;
    end else begin
      inv_exc   <= op_valid && inv_c;
      stk_uflow <= op_valid && any_e;
      pop_valid <= op_valid && pop_en;
      if (op_valid) begin
        of <= 1'b0;
        if (wr_flags) {zf, pf, cf} <= nflags;
        if (pop_en) begin
          pop_idx <= top_ptr;
          top_ptr <= top_ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk
  import fcmp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             mask_invalid,
  input logic             pop_en,
  input logic             st0_empty,
  input logic             sti_empty,
  input logic             zf,
  input logic             pf,
  input logic             cf,
  input logic             of,
  input logic             inv_exc,
  input logic             stk_uflow,
  input logic             pop_valid,
  input logic [PTR_W-1:0] pop_idx,
  input logic [PTR_W-1:0] top_ptr
);
  assert_of_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !of);

  assert_pop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && pop_en |=> pop_valid && (pop_idx == $past(top_ptr))
                           && (top_ptr == $past(top_ptr) + 3'd1));

  assert_uflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (st0_empty || sti_empty) |=> stk_uflow && inv_exc);

  assert_hold_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !mask_invalid |=> !inv_exc || $stable({zf, pf, cf}));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !inv_exc && !stk_uflow && !pop_valid
                  && $stable(top_ptr) && $stable({zf, pf, cf}));

  assert_flag_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf |-> zf && cf);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk chk_i (.*);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_signaling = 1'b0, mask_invalid = 1'b0, pop_en = 1'b0;
  logic [79:0] st0_val = '0, sti_val = '0;
  logic        st0_empty = 1'b0, sti_empty = 1'b0;
  logic        op_ready, zf, pf, cf, of, inv_exc, stk_uflow, pop_valid;
  logic [2:0]  pop_idx, top_ptr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_signaling(op_signaling), .mask_invalid(mask_invalid), .pop_en(pop_en),
    .st0_val(st0_val), .sti_val(sti_val), .st0_empty(st0_empty), .sti_empty(sti_empty),
    .zf(zf), .pf(pf), .cf(cf), .of(of), .inv_exc(inv_exc), .stk_uflow(stk_uflow),
    .pop_valid(pop_valid), .pop_idx(pop_idx), .top_ptr(top_ptr)
  );

  function automatic logic [79:0] fp(bit s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  localparam logic [63:0] ONE_M = 64'h8000_0000_0000_0000;
  logic [79:0] p1, p2, n1, n2, pz, nz, pinf, ninf, qnan, snan, unsup, d1, d2, nbig;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one compare, then sample one cycle after acceptance
  task automatic run_op(logic [79:0] a, logic [79:0] b, bit sig, bit msk, bit pop,
                        bit ae = 1'b0, bit be = 1'b0);
    @(negedge clk);
    st0_val = a; sti_val = b; op_signaling = sig; mask_invalid = msk;
    pop_en = pop; st0_empty = ae; sti_empty = be; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; pop_en = 1'b0; st0_empty = 1'b0; sti_empty = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7", {zf, pf, cf, of}, 4'b1111, "reset flags");
    chk("R7", top_ptr, 0, "reset top");
    chk("R7", {inv_exc, stk_uflow, pop_valid}, 0, "reset pulses");
    chk("R12", op_ready, 1, "ready");
  endtask

  task automatic t_of_on_exception();
    run_op(snan, p1, 1'b0, 1'b0, 1'b0);
    chk("R7", of, 0, "of cleared on exception");
    chk("R6", {zf, pf, cf}, 3'b111, "unmasked keeps reset flags");
    chk("R4", inv_exc, 1, "snan quiet raises");
  endtask

  task automatic t_ordered();
    run_op(p2, p1, 1'b0, 1'b0, 1'b0);
    chk("R1", {zf, pf, cf}, 3'b000, "2>1");
    chk("R1", inv_exc, 0, "no exc");
    run_op(p1, p2, 1'b1, 1'b0, 1'b0);
    chk("R1", {zf, pf, cf}, 3'b001, "1<2");
    run_op(p1, p1, 1'b0, 1'b0, 1'b0);
    chk("R1", {zf, pf, cf}, 3'b100, "1=1");
  endtask

  task automatic t_zeros();
    run_op(p2, p1, 1'b0, 1'b0, 1'b0);
    run_op(pz, nz, 1'b0, 1'b0, 1'b0);
    chk("R3", {zf, pf, cf}, 3'b100, "+0 vs -0");
    run_op(p1, p2, 1'b0, 1'b0, 1'b0);
    run_op(nz, pz, 1'b1, 1'b0, 1'b0);
    chk("R3", {zf, pf, cf}, 3'b100, "-0 vs +0");
  endtask

  task automatic t_magnitude();
    run_op(n2, n1, 1'b0, 1'b0, 1'b0);
    chk("R11", {zf, pf, cf}, 3'b001, "-2<-1");
    run_op(n1, n2, 1'b0, 1'b0, 1'b0);
    chk("R11", {zf, pf, cf}, 3'b000, "-1>-2");
    run_op(ninf, nbig, 1'b0, 1'b0, 1'b0);
    chk("R11", {zf, pf, cf}, 3'b001, "-inf<-big");
    run_op(pinf, p2, 1'b0, 1'b0, 1'b0);
    chk("R11", {zf, pf, cf}, 3'b000, "+inf>2");
    run_op(d1, d2, 1'b0, 1'b0, 1'b0);
    chk("R11", {zf, pf, cf}, 3'b001, "denorm order");
    run_op(d1, pz, 1'b0, 1'b0, 1'b0);
    chk("R11", {zf, pf, cf}, 3'b000, "denorm>0");
  endtask

  task automatic t_nan_variants();
    run_op(qnan, p1, 1'b0, 1'b0, 1'b0);
    chk("R2", {zf, pf, cf}, 3'b111, "qnan quiet unordered");
    chk("R4", inv_exc, 0, "qnan quiet no exc");
    run_op(p1, snan, 1'b0, 1'b1, 1'b0);
    chk("R4", inv_exc, 1, "snan quiet exc");
    run_op(p1, qnan, 1'b1, 1'b1, 1'b0);
    chk("R5", inv_exc, 1, "qnan signaling exc");
    chk("R5", {zf, pf, cf}, 3'b111, "masked qnan flags");
  endtask

  task automatic t_mask();
    run_op(p2, p1, 1'b0, 1'b0, 1'b0);
    run_op(qnan, p1, 1'b1, 1'b0, 1'b0);
    chk("R6", {inv_exc, zf, pf, cf}, 4'b1000, "unmasked holds 000");
    run_op(qnan, p1, 1'b1, 1'b1, 1'b0);
    chk("R6", {inv_exc, zf, pf, cf}, 4'b1111, "masked writes 111");
  endtask

  task automatic t_unsupported();
    run_op(p1, p1, 1'b0, 1'b0, 1'b0);
    run_op(unsup, p1, 1'b0, 1'b1, 1'b0);
    chk("R10", {inv_exc, zf, pf, cf}, 4'b1111, "unnormal quiet");
    run_op(p2, p1, 1'b0, 1'b0, 1'b0);
    run_op(p1, unsup, 1'b1, 1'b0, 1'b0);
    chk("R10", {inv_exc, zf, pf, cf}, 4'b1000, "unnormal signaling unmasked");
  endtask

  task automatic t_empty();
    run_op(p1, p2, 1'b0, 1'b0, 1'b0);
    run_op(p2, p1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9", {stk_uflow, inv_exc}, 2'b11, "st0 empty pulses");
    chk("R9", {zf, pf, cf}, 3'b001, "unmasked underflow holds");
    run_op(p2, p1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9", {stk_uflow, inv_exc, zf, pf, cf}, 5'b11111, "masked underflow");
  endtask

  task automatic t_pop();
    logic [2:0] exp_top;
    exp_top = top_ptr;
    run_op(p1, p2, 1'b0, 1'b0, 1'b0);
    chk("R8", {pop_valid, top_ptr}, {1'b0, exp_top}, "no pop");
    for (int k = 0; k < 9; k++) begin
      run_op(p1, p2, 1'b0, 1'b0, 1'b1);
      chk("R8", {pop_valid, pop_idx}, {1'b1, exp_top}, "pop idx");
      exp_top = exp_top + 3'd1;
      chk("R8", top_ptr, exp_top, "top wraps");
    end
  endtask

  task automatic t_idle();
    logic [2:0] fl;
    logic [2:0] tp;
    fl = {zf, pf, cf};
    tp = top_ptr;
    @(negedge clk);
    st0_val = qnan; op_signaling = 1'b1; pop_en = 1'b1; st0_empty = 1'b1;
    @(negedge clk);
    pop_en = 1'b0; st0_empty = 1'b0;
    chk("R12", {inv_exc, stk_uflow, pop_valid}, 0, "idle no pulses");
    chk("R12", {fl, tp}, {zf, pf, cf, top_ptr}, "idle holds");
  endtask

  initial begin
    p1 = fp(0, 15'h3FFF, ONE_M);   p2 = fp(0, 15'h4000, ONE_M);
    n1 = fp(1, 15'h3FFF, ONE_M);   n2 = fp(1, 15'h4000, ONE_M);
    pz = fp(0, 0, 0);              nz = fp(1, 0, 0);
    pinf = fp(0, 15'h7FFF, ONE_M); ninf = fp(1, 15'h7FFF, ONE_M);
    nbig = fp(1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF);
    qnan = fp(0, 15'h7FFF, 64'hC000_0000_0000_0000);
    snan = fp(0, 15'h7FFF, 64'hA000_0000_0000_0000);
    unsup = fp(0, 15'h3FFF, 64'h4000_0000_0000_0000);
    d1 = fp(0, 0, 64'h1);          d2 = fp(0, 0, 64'h2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_of_on_exception();
    t_ordered();
    t_zeros();
    t_magnitude();
    t_nan_variants();
    t_mask();
    t_unsupported();
    t_empty();
    t_pop();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule